// File: doc/BRIEF.md
# Transport Overhead Serial Drop Port

This block watches a received STS-3 frame that arrives one byte at a time with a marker on the first byte of each frame. It copies the 81-byte transport overhead block (nine rows of nine interleaved columns) into a two-bank store. While the next frame arrives, it shifts the stored overhead of the completed frame out onto three bit-serial ports. The first port carries the full overhead block. The second carries the nine line data-communication bytes. The third carries the two order-wire bytes and the user channel byte.

All three ports run from one overhead clock that the block makes itself by dividing its own clock. Every port output changes at the clock edge on which the overhead clock falls. A consumer can therefore sample on the rising edge of the overhead clock and take a data bit whenever that port's valid strobe is high. Output for a frame begins at the overhead-clock falling edge that follows the next frame marker, so there is one frame of latency.

Top module: `toh_serial_drop`

## Requirements
- R1: The DCC port carries nine bytes in this order: row 6, row 7 and row 8 (1-based), and within each row the interleaved columns 1, 4 and 7. Byte positions are counted from the marked byte. Bytes received before the first marker are discarded.
- R2: `dccValid` is high in exactly the overhead periods 1 to 72 after each frame pulse, which is 72 bits, and low in every other period.
- R3: Every port output changes only at a clock edge on which `ohClk` falls.
- R4: `tohFrame` is high for exactly one overhead period. That period comes just before the first overhead bit, and `tohValid` is low during it.
- R5: The TOH port sends all 81 overhead bytes in received order, row by row and columns 1 to 9. `tohValid` is high for exactly the 648 periods after the frame pulse.
- R6: The order-wire port sends the byte at row 2 column 4, then the byte at row 2 column 7, then the byte at row 9 column 7, over 24 valid periods. `owBound` is high only in the period of the first bit of the first byte.
- R7: Reset holds every valid strobe and pulse low. The overhead captured between marker k and marker k+1 is sent after marker k+1, so nothing is sent before the second marker.
- R8: `ohClk` is low after reset and stays at each level for `OH_HALF` clock cycles.
- R9: Every port sends each byte most-significant bit first, over eight consecutive valid periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | A received byte is present on `inByte` |
| inStart | input | 1 | Marks the first byte of a frame, qualified by `inValid` |
| inByte | input | 8 | Received frame byte |
| ohClk | output | 1 | Overhead output clock shared by all three ports |
| tohFrame | output | 1 | One-period pulse before the first overhead bit |
| tohValid | output | 1 | `tohData` holds an overhead bit |
| tohData | output | 1 | Serial overhead bit |
| dccValid | output | 1 | `dccData` holds a DCC bit |
| dccData | output | 1 | Serial line DCC bit |
| owValid | output | 1 | `owData` holds an order-wire bit |
| owData | output | 1 | Serial order-wire bit |
| owBound | output | 1 | High with the first bit of the first order-wire byte |

## Verification
The assertions assume that each frame is a full 2430 bytes. They also assume that markers are far enough apart for the 649 overhead periods to end before the next marker. Without that, the counts checked per frame would be cut short by the restart. The stimulus keeps to this by following every byte with one or two idle cycles, so a frame lasts well longer than the readout at the divider setting used. Random bytes come from a fixed seed. Some frames are all ones, all zeros, or alternate edge bits, to exercise the bit order.

// File: rtl/toh_drop_pkg.sv
package toh_drop_pkg;

  localparam int STS_N     = 3;
  localparam int ROWS      = 9;
  localparam int ROW_BYTES = 90 * STS_N;
  localparam int TOH_COLS  = 3 * STS_N;
  localparam int TOH_BYTES = ROWS * TOH_COLS;
  localparam int TOH_BITS  = TOH_BYTES * 8;
  localparam int DCC_BYTES = 9;
  localparam int OW_BYTES  = 3;
  localparam int LANES     = 3;
  localparam int IDX_W     = $clog2(TOH_BYTES);
  localparam int PER_W     = $clog2(TOH_BITS + 2);

  // strobes from control to datapath
  typedef struct packed {
    logic             fall;    // ohClk falls at this edge
    logic             active;  // readout running in the coming period
    logic [PER_W-1:0] period;  // index of the coming overhead period
    logic             wrEn;
    logic [IDX_W-1:0] wrIdx;
    logic             wrBank;
    logic             rdBank;
  } ctrlStrobes_t;

  // store position of the k-th line DCC byte (first STS-1, rows 6..8)
  function automatic logic [IDX_W-1:0] dccIndex(input logic [IDX_W-1:0] k);
    int kk;
    int row;
    int col;
    kk  = int'(k);
    row = 5 + kk / 3;
    col = (kk % 3) * STS_N;
    return IDX_W'(row * TOH_COLS + col);
  endfunction

  // store position of the k-th order-wire port byte
  function automatic logic [IDX_W-1:0] owIndex(input logic [IDX_W-1:0] k);
    int pos;
    case (int'(k))
      0:       pos = 1 * TOH_COLS + STS_N;
      1:       pos = 1 * TOH_COLS + 2 * STS_N;
      default: pos = 8 * TOH_COLS + 2 * STS_N;
    endcase
    return IDX_W'(pos);
  endfunction

endpackage

// File: rtl/toh_drop_ctrl.sv
module toh_drop_ctrl
  import toh_drop_pkg::*;
#(
  parameter int OH_HALF = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         inStart,
  output logic         ohClk,
  output ctrlStrobes_t ctl
);

  localparam int HC_W  = (OH_HALF > 1) ? $clog2(OH_HALF) : 1;
  localparam int COL_W = $clog2(ROW_BYTES);
  localparam int ROW_W = $clog2(ROWS);
  localparam logic [PER_W-1:0] PER_END = PER_W'(TOH_BITS + 1);

  logic [HC_W-1:0]  halfCnt;
  logic             ohClkQ;
  logic             toggle;
  logic             fall;
  logic [ROW_W-1:0] rowQ, curRow, nxtRow;
  logic [COL_W-1:0] colQ, curCol, nxtCol;
  logic             seenQ;
  logic             wrBankQ;
  logic             curBank;
  logic             startPend;
  logic             activeQ;
  logic             start;
  logic [PER_W-1:0] perQ, perNxt;
  logic             takeByte;

  always_comb begin
    toggle   = (halfCnt == HC_W'(OH_HALF - 1));
    fall     = toggle & ohClkQ;
    curRow   = inStart ? '0 : rowQ;
    curCol   = inStart ? '0 : colQ;
    if (curCol == COL_W'(ROW_BYTES - 1)) begin
      nxtCol = '0;
      nxtRow = (curRow == ROW_W'(ROWS - 1)) ? '0 : curRow + ROW_W'(1);
    end else begin
      nxtCol = curCol + COL_W'(1);
      nxtRow = curRow;
    end
    curBank  = inStart ? ~wrBankQ : wrBankQ;
    takeByte = inValid & (inStart | seenQ);
    start    = fall & startPend;
    if (start)                perNxt = '0;
    else if (perQ != PER_END) perNxt = perQ + PER_W'(1);
    else                      perNxt = perQ;
  end

  always_comb begin
    ctl.fall   = fall;
    ctl.active = activeQ | start;
    ctl.period = perNxt;
    ctl.wrEn   = takeByte & (curCol < COL_W'(TOH_COLS));
    ctl.wrIdx  = IDX_W'(int'(curRow) * TOH_COLS + int'(curCol));
    ctl.wrBank = curBank;
    ctl.rdBank = ~wrBankQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      halfCnt   <= '0;
      ohClkQ    <= 1'b0;
      rowQ      <= '0;
      colQ      <= '0;
      seenQ     <= 1'b0;
      wrBankQ   <= 1'b0;
      startPend <= 1'b0;
      activeQ   <= 1'b0;
      perQ      <= PER_END;
    end else begin
      halfCnt <= toggle ? '0 : halfCnt + HC_W'(1);
      if (toggle) ohClkQ <= ~ohClkQ;
      if (takeByte) begin
        rowQ <= nxtRow;
        colQ <= nxtCol;
      end
      if (inValid && inStart) begin
        wrBankQ <= ~wrBankQ;
        seenQ   <= 1'b1;
      end
      if (inValid && inStart && seenQ) startPend <= 1'b1;
      else if (start)                  startPend <= 1'b0;
      if (start) activeQ <= 1'b1;
      if (fall)  perQ    <= perNxt;
    end
  end

  assign ohClk = ohClkQ;

  // R7: readout never begins before a frame has been located
  p_active_after_sync_r7 : assert property (@(posedge clk) disable iff (rst)
    ctl.active |-> seenQ);

endmodule

// File: rtl/toh_drop_lane.sv
module toh_drop_lane
  import toh_drop_pkg::*;
#(
  parameter int NBYTES = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fall,
  input  logic             active,
  input  logic [PER_W-1:0] period,
  input  logic [7:0]       curByte,
  output logic [IDX_W-1:0] byteNum,
  output logic             valid,
  output logic             data
);

  localparam int NBITS = NBYTES * 8;
  localparam logic [PER_W-1:0] LAST = PER_W'(NBITS);

  logic             inRange;
  logic [PER_W-1:0] bitOff;
  logic [2:0]       bitSel;

  always_comb begin
    inRange = active && (period != '0) && (period <= LAST);
    bitOff  = period - PER_W'(1);
    byteNum = inRange ? IDX_W'(bitOff >> 3) : '0;
    bitSel  = ~bitOff[2:0];   // most significant bit first
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= 1'b0;
    end else if (fall) begin
      valid <= inRange;
      data  <= inRange & curByte[bitSel];
    end
  end

endmodule

// File: rtl/toh_drop_datapath.sv
module toh_drop_datapath
  import toh_drop_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic [7:0]   inByte,
  input  ctrlStrobes_t ctl,
  output logic         tohFrame,
  output logic         tohValid,
  output logic         tohData,
  output logic         dccValid,
  output logic         dccData,
  output logic         owValid,
  output logic         owData,
  output logic         owBound
);

  localparam int LANE_BYTES [LANES] = '{TOH_BYTES, DCC_BYTES, OW_BYTES};

  logic [7:0]       store [2][TOH_BYTES];
  logic [IDX_W-1:0] laneByteNum [LANES];
  logic [IDX_W-1:0] laneIdx [LANES];
  logic [7:0]       laneByte [LANES];
  logic [LANES-1:0] laneValid;
  logic [LANES-1:0] laneData;

  always_ff @(posedge clk) begin
    if (ctl.wrEn) store[ctl.wrBank][ctl.wrIdx] <= inByte;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    toh_drop_lane #(.NBYTES(LANE_BYTES[i])) u_lane (
      .clk     (clk),
      .rst     (rst),
      .fall    (ctl.fall),
      .active  (ctl.active),
      .period  (ctl.period),
      .curByte (laneByte[i]),
      .byteNum (laneByteNum[i]),
      .valid   (laneValid[i]),
      .data    (laneData[i])
    );
    if (i == 0) begin : g_full
      assign laneIdx[i] = laneByteNum[i];
    end else if (i == 1) begin : g_dcc
      assign laneIdx[i] = dccIndex(laneByteNum[i]);
    end else begin : g_ow
      assign laneIdx[i] = owIndex(laneByteNum[i]);
    end
    assign laneByte[i] = store[ctl.rdBank][laneIdx[i]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tohFrame <= 1'b0;
      owBound  <= 1'b0;
    end else if (ctl.fall) begin
      tohFrame <= ctl.active && (ctl.period == '0);
      owBound  <= ctl.active && (ctl.period == PER_W'(1));
    end
  end

  assign tohValid = laneValid[0];
  assign tohData  = laneData[0];
  assign dccValid = laneValid[1];
  assign dccData  = laneData[1];
  assign owValid  = laneValid[2];
  assign owData   = laneData[2];

  // checker: DCC periods since the last frame pulse
  logic [PER_W-1:0] dccRun;
  always_ff @(posedge clk) begin
    if (rst || tohFrame)             dccRun <= '0;
    else if (ctl.fall && dccValid)   dccRun <= dccRun + PER_W'(1);
  end

  // R2: no more than nine DCC bytes per frame
  p_dcc_limit_r2 : assert property (@(posedge clk) disable iff (rst)
    dccRun <= PER_W'(DCC_BYTES * 8));

  // R4: overhead bits start only right after the frame pulse
  p_frame_then_bits_r4 : assert property (@(posedge clk) disable iff (rst)
    $rose(tohValid) |-> $past(tohFrame));

  // R6: boundary pulse opens the order-wire burst
  p_bound_first_e1_r6 : assert property (@(posedge clk) disable iff (rst)
    $rose(owBound) |-> $rose(owValid));

endmodule

// File: rtl/toh_serial_drop.sv
module toh_serial_drop
  import toh_drop_pkg::*;
#(
  parameter int OH_HALF = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       inStart,
  input  logic [7:0] inByte,
  output logic       ohClk,
  output logic       tohFrame,
  output logic       tohValid,
  output logic       tohData,
  output logic       dccValid,
  output logic       dccData,
  output logic       owValid,
  output logic       owData,
  output logic       owBound
);

  ctrlStrobes_t ctl;

  toh_drop_ctrl #(.OH_HALF(OH_HALF)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inStart (inStart),
    .ohClk   (ohClk),
    .ctl     (ctl)
  );

  toh_drop_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .inByte   (inByte),
    .ctl      (ctl),
    .tohFrame (tohFrame),
    .tohValid (tohValid),
    .tohData  (tohData),
    .dccValid (dccValid),
    .dccData  (dccData),
    .owValid  (owValid),
    .owData   (owData),
    .owBound  (owBound)
  );

  // R3: port outputs move only with a falling overhead clock
  p_edge_align_r3 : assert property (@(posedge clk) disable iff (rst)
    !$stable({tohFrame, tohValid, tohData, dccValid, dccData, owValid, owData, owBound})
      |-> $fell(ohClk));

endmodule

// File: tb/toh_serial_drop_test.sv
module toh_serial_drop_test;

  localparam int CLK_PERIOD = 10;
  localparam int OH_HALF    = 2;
  localparam int NF         = 6;
  localparam int TB_BITS    = 648;

  logic clk = 1'b0;
  logic rst;
  logic inValid, inStart;
  logic [7:0] inByte;
  logic ohClk, tohFrame, tohValid, tohData, dccValid, dccData, owValid, owData, owBound;

  int checks = 0;
  int failures = 0;
  logic [7:0] refToh [0:NF][0:80];

  always #(CLK_PERIOD / 2) clk = ~clk;

  toh_serial_drop #(.OH_HALF(OH_HALF)) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inStart(inStart), .inByte(inByte),
    .ohClk(ohClk), .tohFrame(tohFrame), .tohValid(tohValid), .tohData(tohData),
    .dccValid(dccValid), .dccData(dccData), .owValid(owValid), .owData(owData),
    .owBound(owBound)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int dccPos(input int k);
    return (5 + k / 3) * 9 + (k % 3) * 3;
  endfunction

  function automatic int owPos(input int k);
    if (k == 0) return 12;
    if (k == 1) return 15;
    return 78;
  endfunction

  function automatic logic [7:0] genByte(input int f, input int r, input int c);
    case (f)
      2: return 8'hFF;
      3: return ((r + c) % 2 == 1) ? 8'h01 : 8'h80;
      4: return 8'h00;
      default: return 8'($urandom_range(0, 255));
    endcase
  endfunction

  task automatic sendByte(input logic [7:0] b, input logic s);
    @(negedge clk);
    inValid = 1'b1;
    inStart = s;
    inByte  = b;
    @(negedge clk);
    inValid = 1'b0;
    inStart = 1'b0;
    repeat ($urandom_range(0, 1)) @(negedge clk);
  endtask

  task automatic sendFrame(input int f);
    for (int r = 0; r < 9; r++) begin
      for (int c = 0; c < 270; c++) begin
        logic [7:0] b;
        b = genByte(f, r, c);
        if (c < 9) refToh[f][r * 9 + c] = b;
        sendByte(b, (r == 0 && c == 0));
      end
    end
  endtask

  // monitor state
  bit   havePrev = 0;
  logic prevOh;
  logic [7:0] outsPrev;
  int   runLen = 0, nTrans = 0;
  int   alignErr = 0, halfErr = 0, preErr = 0;
  int   pulses = 0, p = 0;
  int   tohCnt = 0, dccCnt = 0, owCnt = 0;
  bit   lastFrame = 0;

  task automatic samplePeriod();
    int f, b;
    bit expT, expD, expO;
    if (tohFrame) begin
      if (lastFrame) chk(1'b0, "R4 frame pulse wider than one period", 2, 1);
      chk(!tohValid, "R4 valid low during frame pulse", int'(tohValid), 0);
      if (pulses > 0) begin
        chk(tohCnt == TB_BITS, "R5 toh bits per frame", tohCnt, TB_BITS);
        chk(dccCnt == 72, "R2 dcc bits per frame", dccCnt, 72);
        chk(owCnt == 24, "R6 order-wire bits per frame", owCnt, 24);
      end
      pulses++;
      p = 0;
      tohCnt = 0; dccCnt = 0; owCnt = 0;
    end else if (pulses > 0) begin
      p++;
    end
    lastFrame = tohFrame;
    if (pulses == 0) begin
      if (tohValid || dccValid || owValid || owBound) preErr++;
      return;
    end
    f = pulses - 1;
    b = p - 1;
    expT = (p >= 1 && p <= TB_BITS);
    expD = (p >= 1 && p <= 72);
    expO = (p >= 1 && p <= 24);
    chk(tohValid == expT, "R5 toh valid window", int'(tohValid), int'(expT));
    chk(dccValid == expD, "R2 dcc valid window", int'(dccValid), int'(expD));
    chk(owValid == expO, "R6 order-wire valid window", int'(owValid), int'(expO));
    chk(owBound == (p == 1), "R6 boundary pulse", int'(owBound), int'(p == 1));
    if (tohValid) tohCnt++;
    if (dccValid) dccCnt++;
    if (owValid)  owCnt++;
    if (expT && f <= NF)
      chk(tohData == refToh[f][b / 8][7 - b % 8], "R5 R9 toh data bit",
          int'(tohData), int'(refToh[f][b / 8][7 - b % 8]));
    if (expD && f <= NF)
      chk(dccData == refToh[f][dccPos(b / 8)][7 - b % 8], "R1 R9 dcc data bit",
          int'(dccData), int'(refToh[f][dccPos(b / 8)][7 - b % 8]));
    if (expO && f <= NF)
      chk(owData == refToh[f][owPos(b / 8)][7 - b % 8], "R6 R9 order-wire data bit",
          int'(owData), int'(refToh[f][owPos(b / 8)][7 - b % 8]));
  endtask

  always @(negedge clk) begin
    logic [7:0] outsNow;
    if (rst) begin
      havePrev = 0;
      runLen = 0;
      nTrans = 0;
    end else begin
      outsNow = {tohFrame, tohValid, tohData, dccValid, dccData, owValid, owData, owBound};
      if (havePrev) begin
        if (outsNow != outsPrev && !(prevOh && !ohClk)) alignErr++;
        if (ohClk == prevOh) runLen++;
        else begin
          if (nTrans > 0 && runLen != OH_HALF) halfErr++;
          nTrans++;
          runLen = 1;
        end
        if (!prevOh && ohClk) samplePeriod();
      end else begin
        runLen = 1;
      end
      outsPrev = outsNow;
      prevOh   = ohClk;
      havePrev = 1;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1;
    inValid = 1'b0;
    inStart = 1'b0;
    inByte  = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state, R8 clock level
    chk({tohFrame, tohValid, dccValid, owValid, owBound} == 5'b0, "R7 reset state",
        int'({tohFrame, tohValid, dccValid, owValid, owBound}), 0);
    chk(ohClk == 1'b0, "R8 ohClk low after reset", int'(ohClk), 0);
    // bytes with no marker yet: must be discarded (R1)
    repeat (40) sendByte(8'($urandom_range(0, 255)), 1'b0);
    for (int f = 0; f <= NF; f++) sendFrame(f);
    repeat (3000) @(negedge clk);
    chk(pulses == NF, "R7 frame pulses after one frame latency", pulses, NF);
    chk(preErr == 0, "R7 outputs quiet before second marker", preErr, 0);
    chk(alignErr == 0, "R3 outputs change only on ohClk fall", alignErr, 0);
    chk(halfErr == 0, "R8 ohClk half period length", halfErr, 0);
    chk(tohCnt == TB_BITS, "R5 toh bits in last frame", tohCnt, TB_BITS);
    chk(dccCnt == 72, "R2 dcc bits in last frame", dccCnt, 72);
    chk(owCnt == 24, "R6 order-wire bits in last frame", owCnt, 24);
    summary();
    $finish;
  end

endmodule